// File: doc/BRIEF.md
# FIFO Flag Offset Programming Controller

This block holds the four threshold offsets used by the almost-empty and almost-full flags of two FIFOs that carry data in opposite directions. Each offset is set in one of two ways. A preset is latched from a two-bit flag-select input on the rising edge of a FIFO's reset. Alternatively, in a port-load sequence, the first four words written on the write port after reset are taken as offset values instead of FIFO data.

All logic runs on the write-port clock, and the two active-low FIFO resets are sampled on that clock. A reset edge on the first FIFO sets the reverse-port almost-empty offset and the forward-port almost-full offset. A reset edge on the second FIFO sets the other two. While a port-load sequence runs, the block flags each write to be steered away from FIFO memory. It holds the programming-done output low, and that output gates the reverse-direction input-ready flag. Values written out of range are forced into range, and a sticky error bit records that this happened.

Top module: `flag_offset_ctrl`

## Requirements
- R1: While both resets are low at a clock edge (master reset), all four offsets become 0, and prog_done, clamp_err and wr_divert are low after that edge.
- R2: Each preset code on fsel (FS1 in bit 1, FS0 in bit 0) sets a fixed offset: 2'b11 gives 64, 2'b10 gives 16 and 2'b01 gives 8. A rising edge of rst1_n with a preset code sets ae_rev_ofs and af_fwd_ofs to that value and leaves the other two offsets unchanged.
- R3: A rising edge of rst2_n with a preset code sets ae_fwd_ofs and af_rev_ofs to that value and leaves the other two offsets unchanged.
- R4: A reset rising edge with a preset code drives prog_done high after that edge.
- R5: A reset rising edge with fsel = 2'b00, while both resets are high, starts a port load. From the next edge, prog_done is low and wr_divert follows wr_en.
- R6: During a port load, the four accepted writes fill, in this order: af_fwd_ofs, ae_rev_ofs, af_rev_ofs, ae_fwd_ofs. Each value is taken from wr_data[8:0] with bit 8 as MSB.
- R7: After the fourth accepted write, prog_done is high. Further writes are not diverted and do not change any offset.
- R8: A port-load value of 0 is stored as 1, and a value above 508 is stored as 508. Either case sets clamp_err, which stays set until master reset or the start of a new port load.
- R9: A new port-load start in the middle of a sequence restarts it, so that the next write again fills af_fwd_ofs.
- R10: While either reset is low, writes are neither diverted nor counted as offset writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-port clock |
| rst1_n | input | 1 | Active-low reset of the forward FIFO |
| rst2_n | input | 1 | Active-low reset of the reverse FIFO |
| fsel | input | 2 | Flag select: 11=64, 10=16, 01=8, 00=port load |
| wr_en | input | 1 | Write strobe on the write port |
| wr_data | input | 36 | Write data; bits 8:0 carry offset values |
| ae_rev_ofs | output | 9 | Offset for the reverse-port almost-empty flag |
| af_fwd_ofs | output | 9 | Offset for the forward-port almost-full flag |
| ae_fwd_ofs | output | 9 | Offset for the forward-port almost-empty flag |
| af_rev_ofs | output | 9 | Offset for the reverse-port almost-full flag |
| wr_divert | output | 1 | High while the current write is taken as an offset |
| prog_done | output | 1 | High once offsets are set; gates reverse input-ready |
| clamp_err | output | 1 | Sticky: a port-load value was forced into range |

## Verification
The assertions check several properties on every cycle. Diversion and done never overlap. No write is diverted while a reset is held. Each accepted write advances the slot or ends the sequence. An offset pair moves only on its own reset edge or on a port-load write. The error bit rises only after a port-load write, and master reset clears all state. Only the bench scenarios can show the values themselves: the preset table, the fixed fill order, the selection of the low data bits, the clamp bounds, and where a sequence resumes after a mid-sequence restart.

// File: rtl/fop_pkg.sv
package fop_pkg;
  localparam int NSLOT = 4;

  typedef enum logic [1:0] {
    ST_BLANK = 2'd0,
    ST_LOAD  = 2'd1,
    ST_RUN   = 2'd2
  } prog_state_e;

  typedef enum logic [1:0] {
    SEL_PORT = 2'b00,
    SEL_LOW  = 2'b01,
    SEL_MID  = 2'b10,
    SEL_HIGH = 2'b11
  } fsel_e;
endpackage

// File: rtl/fop_edge.sv
module fop_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) prev_q <= lvl[i];
    assign rise[i] = lvl[i] & ~prev_q;
  end
endmodule

// File: rtl/fop_seq.sv
module fop_seq
  import fop_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              mst_rst,
  input  logic              start_load,
  input  logic              preset_hit,
  input  logic              wr_req,
  output prog_state_e       state,
  output logic [SLOT_W-1:0] slot,
  output logic              accept
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);

  assign accept = (state == ST_LOAD) && wr_req;

  always_ff @(posedge clk) begin
    if (mst_rst) begin
      state <= ST_BLANK;
      slot  <= '0;
    end else if (start_load) begin
      state <= ST_LOAD;
      slot  <= '0;
    end else if (preset_hit) begin
      state <= ST_RUN;
      slot  <= '0;
    end else if (accept) begin
      if (slot == LAST_SLOT) begin
        state <= ST_RUN;
        slot  <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fop_regs.sv
module fop_regs
  import fop_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 512,
  parameter int OFS_W  = 9,
  parameter int SLOT_W = 2,
  parameter int PRE_HI = 64,
  parameter int PRE_MD = 16,
  parameter int PRE_LO = 8
) (
  input  logic              clk,
  input  logic              mst_rst,
  input  logic [1:0]        rise,
  input  logic [1:0]        fsel,
  input  logic              start_load,
  input  logic              accept,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  ofs [NSLOT],
  output logic              clamp_err
);
  localparam logic [OFS_W-1:0] OFS_MIN = OFS_W'(1);
  localparam logic [OFS_W-1:0] OFS_MAX = OFS_W'(DEPTH - 4);

  function automatic logic [OFS_W-1:0] preset_of(input logic [1:0] code);
    case (code)
      SEL_HIGH: return OFS_W'(PRE_HI);
      SEL_MID:  return OFS_W'(PRE_MD);
      SEL_LOW:  return OFS_W'(PRE_LO);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [OFS_W:0] fit_offset(input logic [OFS_W-1:0] raw);
    if (raw < OFS_MIN)      return {1'b1, OFS_MIN};
    else if (raw > OFS_MAX) return {1'b1, OFS_MAX};
    else                    return {1'b0, raw};
  endfunction

  logic [OFS_W:0]   fitted;
  logic [OFS_W-1:0] preset_val;
  logic             is_preset;

  assign fitted     = fit_offset(wr_data[OFS_W-1:0]);
  assign preset_val = preset_of(fsel);
  assign is_preset  = (fsel != SEL_PORT);

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam int PAIR = k / 2;
    always_ff @(posedge clk) begin
      if (mst_rst) begin
        ofs[k] <= '0;
      end else if (rise[PAIR] && is_preset) begin
        ofs[k] <= preset_val;
      end else if (accept && (slot == SLOT_W'(k))) begin
        ofs[k] <= fitted[OFS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mst_rst || start_load) clamp_err <= 1'b0;
    else if (accept && fitted[OFS_W]) clamp_err <= 1'b1;
  end
endmodule

// File: rtl/flag_offset_ctrl.sv
module flag_offset_ctrl
  import fop_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 512,
  parameter int OFS_W  = $clog2(DEPTH),
  parameter int PRE_HI = 64,
  parameter int PRE_MD = 16,
  parameter int PRE_LO = 8
) (
  input  logic              clk,
  input  logic              rst1_n,
  input  logic              rst2_n,
  input  logic [1:0]        fsel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  ae_rev_ofs,
  output logic [OFS_W-1:0]  af_fwd_ofs,
  output logic [OFS_W-1:0]  ae_fwd_ofs,
  output logic [OFS_W-1:0]  af_rev_ofs,
  output logic              wr_divert,
  output logic              prog_done,
  output logic              clamp_err
);
  localparam int SLOT_W = $clog2(NSLOT);

  logic [1:0]        rise;
  logic              mst_rst;
  logic              both_hi;
  logic              start_load;
  logic              preset_hit;
  logic              wr_req;
  logic              accept;
  logic [SLOT_W-1:0] slot;
  prog_state_e       state;
  logic [OFS_W-1:0]  ofs [NSLOT];

  assign mst_rst    = !rst1_n && !rst2_n;
  assign both_hi    = rst1_n && rst2_n;
  assign start_load = (fsel == SEL_PORT) && (|rise) && both_hi;
  assign preset_hit = (fsel != SEL_PORT) && (|rise);
  assign wr_req     = wr_en && both_hi && !(|rise);

  fop_edge #(.N(2)) u_edge (
    .clk  (clk),
    .lvl  ({rst2_n, rst1_n}),
    .rise (rise)
  );

  fop_seq #(.SLOT_W(SLOT_W)) u_seq (
    .clk        (clk),
    .mst_rst    (mst_rst),
    .start_load (start_load),
    .preset_hit (preset_hit),
    .wr_req     (wr_req),
    .state      (state),
    .slot       (slot),
    .accept     (accept)
  );

  fop_regs #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .OFS_W  (OFS_W),
    .SLOT_W (SLOT_W),
    .PRE_HI (PRE_HI),
    .PRE_MD (PRE_MD),
    .PRE_LO (PRE_LO)
  ) u_regs (
    .clk        (clk),
    .mst_rst    (mst_rst),
    .rise       (rise),
    .fsel       (fsel),
    .start_load (start_load),
    .accept     (accept),
    .slot       (slot),
    .wr_data    (wr_data),
    .ofs        (ofs),
    .clamp_err  (clamp_err)
  );

  // slot order: 0 fwd almost-full, 1 rev almost-empty, 2 rev almost-full, 3 fwd almost-empty
  assign af_fwd_ofs = ofs[0];
  assign ae_rev_ofs = ofs[1];
  assign af_rev_ofs = ofs[2];
  assign ae_fwd_ofs = ofs[3];
  assign wr_divert  = accept;
  assign prog_done  = (state == ST_RUN);
endmodule

// File: rtl/flag_offset_ctrl_chk.sv
module flag_offset_ctrl_chk #(
  parameter int OFS_W  = 9,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst1_n,
  input logic              rst2_n,
  input logic [1:0]        fsel,
  input logic [1:0]        rise,
  input logic              accept,
  input logic [SLOT_W-1:0] slot,
  input logic              prog_done,
  input logic              wr_divert,
  input logic              clamp_err,
  input logic [OFS_W-1:0]  ae_rev_ofs,
  input logic [OFS_W-1:0]  af_fwd_ofs,
  input logic [OFS_W-1:0]  ae_fwd_ofs,
  input logic [OFS_W-1:0]  af_rev_ofs
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!rst1_n && !rst2_n) armed <= 1'b1;

  a_r1_master_clear: assert property (@(posedge clk) disable iff (!armed)
    (!rst1_n && !rst2_n) |=> (!prog_done && !clamp_err && ae_rev_ofs == '0 &&
      af_fwd_ofs == '0 && ae_fwd_ofs == '0 && af_rev_ofs == '0));

  a_r2_pair1_stable: assert property (@(posedge clk) disable iff (!armed)
    ((rst1_n || rst2_n) && !rise[0] && !accept) |=> ($stable(ae_rev_ofs) && $stable(af_fwd_ofs)));

  a_r3_pair2_stable: assert property (@(posedge clk) disable iff (!armed)
    ((rst1_n || rst2_n) && !rise[1] && !accept) |=> ($stable(ae_fwd_ofs) && $stable(af_rev_ofs)));

  a_r4_preset_done: assert property (@(posedge clk) disable iff (!armed)
    ((|rise) && fsel != 2'b00) |=> prog_done);

  a_r5_divert_not_done: assert property (@(posedge clk) disable iff (!armed)
    wr_divert |-> !prog_done);

  a_r6_slot_advance: assert property (@(posedge clk) disable iff (!armed)
    accept |=> (prog_done || slot == $past(slot) + 1'b1));

  a_r8_err_source: assert property (@(posedge clk) disable iff (!armed)
    $rose(clamp_err) |-> $past(accept));

  a_r10_no_divert_in_reset: assert property (@(posedge clk) disable iff (!armed)
    (!rst1_n || !rst2_n) |-> !wr_divert);
endmodule

bind flag_offset_ctrl flag_offset_ctrl_chk #(.OFS_W(OFS_W), .SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst1_n     (rst1_n),
  .rst2_n     (rst2_n),
  .fsel       (fsel),
  .rise       (rise),
  .accept     (accept),
  .slot       (slot),
  .prog_done  (prog_done),
  .wr_divert  (wr_divert),
  .clamp_err  (clamp_err),
  .ae_rev_ofs (ae_rev_ofs),
  .af_fwd_ofs (af_fwd_ofs),
  .ae_fwd_ofs (ae_fwd_ofs),
  .af_rev_ofs (af_rev_ofs)
);

// File: tb/flag_offset_ctrl_bench.sv
module flag_offset_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst1_n = 1'b0;
  logic        rst2_n = 1'b0;
  logic [1:0]  fsel = 2'b00;
  logic        wr_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [8:0]  ae_rev_ofs, af_fwd_ofs, ae_fwd_ofs, af_rev_ofs;
  logic        wr_divert, prog_done, clamp_err;
  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  flag_offset_ctrl u_flag_offset_ctrl (
    .clk(clk), .rst1_n(rst1_n), .rst2_n(rst2_n), .fsel(fsel),
    .wr_en(wr_en), .wr_data(wr_data),
    .ae_rev_ofs(ae_rev_ofs), .af_fwd_ofs(af_fwd_ofs),
    .ae_fwd_ofs(ae_fwd_ofs), .af_rev_ofs(af_rev_ofs),
    .wr_divert(wr_divert), .prog_done(prog_done), .clamp_err(clamp_err)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic chk_ofs(input string tag, input int x1, input int y1, input int x2, input int y2);
    chk({tag, " ae_rev"}, ae_rev_ofs, x1);
    chk({tag, " af_fwd"}, af_fwd_ofs, y1);
    chk({tag, " ae_fwd"}, ae_fwd_ofs, x2);
    chk({tag, " af_rev"}, af_rev_ofs, y2);
  endtask

  // both resets low for three edges, then release both with the given select
  task automatic master_reset(input logic [1:0] sel);
    @(negedge clk);
    rst1_n = 1'b0; rst2_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    fsel = sel;
    rst1_n = 1'b1; rst2_n = 1'b1;
    @(negedge clk);
  endtask

  // one write; divert is checked during the write cycle
  task automatic do_write(input string tag, input int val, input int exp_div);
    wr_en = 1'b1;
    wr_data = {27'h5A5A5A5, 9'(val)};
    #1 chk({tag, " wr_divert"}, wr_divert, exp_div);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_r1_reset;
    @(negedge clk);
    rst1_n = 1'b0; rst2_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_ofs("R1 reset", 0, 0, 0, 0);
    chk("R1 prog_done", prog_done, 0);
    chk("R1 clamp_err", clamp_err, 0);
    chk("R1 wr_divert", wr_divert, 0);
  endtask

  task automatic t_r2_r3_r4_presets;
    master_reset(2'b11);
    chk_ofs("R2 R3 preset 64", 64, 64, 64, 64);
    chk("R4 done after preset", prog_done, 1);
    fsel = 2'b10; rst1_n = 1'b0;
    repeat (2) @(negedge clk);
    rst1_n = 1'b1;
    @(negedge clk);
    chk_ofs("R2 rst1 preset 16", 16, 16, 64, 64);
    chk("R4 done rst1", prog_done, 1);
    fsel = 2'b01; rst2_n = 1'b0;
    repeat (2) @(negedge clk);
    rst2_n = 1'b1;
    @(negedge clk);
    chk_ofs("R3 rst2 preset 8", 16, 16, 8, 8);
  endtask

  task automatic t_r5_r6_r7_portload;
    master_reset(2'b00);
    chk("R5 not done in load", prog_done, 0);
    do_write("R5 w0", 100, 1);
    do_write("R5 w1", 200, 1);
    chk("R7 not done mid", prog_done, 0);
    do_write("R5 w2", 300, 1);
    do_write("R5 w3", 400, 1);
    chk_ofs("R6 order", 200, 100, 400, 300);
    chk("R7 done", prog_done, 1);
    chk("R8 no clamp", clamp_err, 0);
    do_write("R7 extra", 50, 0);
    chk_ofs("R7 unchanged", 200, 100, 400, 300);
  endtask

  task automatic t_r8_clamp;
    master_reset(2'b00);
    do_write("R8 w0", 0, 1);
    chk("R8 err set", clamp_err, 1);
    do_write("R8 w1", 509, 1);
    do_write("R8 w2", 511, 1);
    do_write("R8 w3", 508, 1);
    chk_ofs("R8 clamp", 508, 1, 508, 508);
    chk("R8 sticky", clamp_err, 1);
    fsel = 2'b00; rst1_n = 1'b0;
    repeat (2) @(negedge clk);
    rst1_n = 1'b1;
    @(negedge clk);
    chk("R8 cleared by new load", clamp_err, 0);
  endtask

  task automatic t_r9_r10_restart;
    master_reset(2'b00);
    do_write("R9 w0", 10, 1);
    do_write("R9 w1", 20, 1);
    rst1_n = 1'b0;
    @(negedge clk);
    do_write("R10 write in reset", 77, 0);
    chk_ofs("R10 no effect", 20, 10, 0, 0);
    rst1_n = 1'b1;
    @(negedge clk);
    chk("R9 restart not done", prog_done, 0);
    do_write("R9 r0", 30, 1);
    chk("R9 first slot refilled", af_fwd_ofs, 30);
    do_write("R9 r1", 40, 1);
    do_write("R9 r2", 50, 1);
    do_write("R9 r3", 60, 1);
    chk_ofs("R9 after restart", 40, 30, 60, 50);
    chk("R9 done", prog_done, 1);
  endtask

  initial begin
    t_r1_reset();
    t_r2_r3_r4_presets();
    t_r5_r6_r7_portload();
    t_r8_clamp();
    t_r9_r10_restart();
    t_r1_reset();
    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule